// File: doc/BRIEF.md
# Conditional branch evaluation unit

This block performs the arithmetic half of a conditional branch on a 64-bit general register. A 32-bit signed immediate is widened to 64 bits and then adjusted at a bit position derived from a 4-bit condition code. The adjustment sets one bit and clears the bit just below it. The adjusted value is added to the register. A window of bits in the sum, starting at that same position, is then tested for zero. The sum is always the register's new value. The taken flag tells the surrounding pipeline whether to redirect. That pipeline selects the register, resolves the target and steers the program counter.

Because the bit under the window is forced low on every add, the same branch can only be taken a bounded number of times in a row. The unit accepts one operation per clock and returns the result one clock later. The window width and the offset added to the condition code are elaboration parameters. Illegal combinations of the two stop elaboration.

Top module: `cbr_eval`

## Requirements
- R1: The adjust position is p = cond_i + JUMP_OFFSET (JUMP_OFFSET default 8), and bit p of the value added to the register is 1.
- R2: When p > 0, bit p-1 of the added value is 0. When p = 0, which can only happen with JUMP_OFFSET 0 and cond_i 0, no bit below p is altered.
- R3: All other bits of the added value equal imm_i sign-extended from 32 to 64 bits.
- R4: result_o equals reg_i plus the added value modulo 2^64, whether or not the branch is taken.
- R5: taken_o is 1 exactly when bits p through p+JUMP_BITS-1 of the sum are all zero (JUMP_BITS default 8). With both parameters at 8, cond_i 3 tests bits 11..18 (mask 0x7F800).
- R6: valid_o rises one clock after an accepted valid_i, with result_o and taken_o for that input. Inputs presented on consecutive clocks yield results on consecutive clocks.
- R7: While valid_o is 0, taken_o is 0 and result_o keeps its last value.
- R8: After reset, valid_o, taken_o and result_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands present this cycle |
| reg_i | input | 64 | Current register value |
| imm_i | input | 32 | Signed immediate |
| cond_i | input | 4 | Condition code selecting the adjust position |
| valid_o | output | 1 | Result present this cycle |
| result_o | output | 64 | Updated register value |
| taken_o | output | 1 | Branch condition met |

## Verification
The assertions on the adjusted immediate assume that imm_i and cond_i are never unknown. They are checked on every clock, not only on valid cycles. The bench therefore drives every operand input with a defined value from time zero, including idle cycles. Stimulus keeps JUMP_BITS + JUMP_OFFSET within 16 so the window never leaves the word. A second instance with a zero offset reaches the p = 0 corner. Register values are chosen so that sums land exactly on, just inside and just outside the tested window.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  localparam int DATA_W = 64;
  localparam int IMM_W  = 32;
  localparam int POS_W  = $clog2(DATA_W);
  typedef logic [DATA_W-1:0] word_t;
  typedef logic [POS_W-1:0]  pos_t;
endpackage

// File: rtl/cbr_imm_build.sv
module cbr_imm_build
  import cbr_pkg::*;
#(
  parameter int COND_W      = 4,
  parameter int JUMP_OFFSET = 8
) (
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [COND_W-1:0] cond_i,
  output pos_t              pos_o,
  output word_t             addend_o
);
  localparam pos_t OFF_P = POS_W'(JUMP_OFFSET);

  word_t sext;
  word_t set_bit;

  always_comb begin
    pos_o    = POS_W'(cond_i) + OFF_P;
    sext     = {{(DATA_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
    set_bit  = word_t'(1) << pos_o;
    // shifting the set bit down one gives the bit to clear; at p = 0 it vanishes
    addend_o = (sext | set_bit) & ~(set_bit >> 1);
  end
endmodule

// File: rtl/cbr_window_test.sv
module cbr_window_test
  import cbr_pkg::*;
#(
  parameter int JUMP_BITS = 8
) (
  input  word_t sum_i,
  input  pos_t  pos_i,
  output logic  hit_o
);
  localparam word_t BASE_MASK = word_t'((64'd1 << JUMP_BITS) - 64'd1);

  word_t mask;

  always_comb begin
    mask  = BASE_MASK << pos_i;
    hit_o = ~|(sum_i & mask);
  end
endmodule

// File: rtl/cbr_eval.sv
module cbr_eval
  import cbr_pkg::*;
#(
  parameter int COND_W      = 4,
  parameter int JUMP_BITS   = 8,
  parameter int JUMP_OFFSET = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [63:0]       reg_i,
  input  logic [31:0]       imm_i,
  input  logic [COND_W-1:0] cond_i,
  output logic              valid_o,
  output logic [63:0]       result_o,
  output logic              taken_o
);
  if (JUMP_BITS <= 0) begin : g_bad_bits
    $error("cbr_eval: JUMP_BITS must be positive");
  end
  if (JUMP_OFFSET < 0) begin : g_bad_off
    $error("cbr_eval: JUMP_OFFSET must not be negative");
  end
  if (JUMP_BITS + JUMP_OFFSET > 16) begin : g_bad_sum
    $error("cbr_eval: JUMP_BITS + JUMP_OFFSET must not exceed 16");
  end

  pos_t  pos;
  word_t addend;
  word_t sum;
  logic  hit;

  cbr_imm_build #(.COND_W(COND_W), .JUMP_OFFSET(JUMP_OFFSET)) u_imm (
    .imm_i   (imm_i),
    .cond_i  (cond_i),
    .pos_o   (pos),
    .addend_o(addend)
  );

  assign sum = reg_i + addend;

  cbr_window_test #(.JUMP_BITS(JUMP_BITS)) u_win (
    .sum_i(sum),
    .pos_i(pos),
    .hit_o(hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      taken_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      taken_o <= valid_i & hit;
      if (valid_i) result_o <= sum;
    end
  end

  assert_bit_set_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addend[pos] == 1'b1);

  assert_below_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos != '0) |-> addend[pos - POS_W'(1)] == 1'b0);

  assert_sign_ext_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addend[DATA_W-1:IMM_W] == {(DATA_W-IMM_W){imm_i[IMM_W-1]}});

  assert_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> valid_o == $past(valid_i));

  assert_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !taken_o);

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !valid_o) |-> $stable(result_o));
endmodule

// File: tb/cbr_eval_test.sv
module cbr_eval_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] reg_i = '0;
  logic [31:0] imm_i = '0;
  logic [3:0]  cond_i = '0;
  logic        valid_o, taken_o, valid_z, taken_z;
  logic [63:0] result_o, result_z;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [63:0] last_s8 = '0;

  typedef struct {
    logic [63:0] s8;
    logic        t8;
    logic [63:0] s0;
    logic        t0;
    string       tag;
  } item_t;
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  cbr_eval #(.JUMP_BITS(8), .JUMP_OFFSET(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .reg_i(reg_i), .imm_i(imm_i),
    .cond_i(cond_i), .valid_o(valid_o), .result_o(result_o), .taken_o(taken_o));

  cbr_eval #(.JUMP_BITS(8), .JUMP_OFFSET(0)) uut_z (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .reg_i(reg_i), .imm_i(imm_i),
    .cond_i(cond_i), .valid_o(valid_z), .result_o(result_z), .taken_o(taken_z));

  function automatic void model(input logic [63:0] r, input logic [31:0] im,
                                input int c, input int off,
                                output logic [63:0] s, output logic t);
    logic [63:0] a;
    int p;
    p = c + off;
    a = {{32{im[31]}}, im};
    a[p] = 1'b1;
    if (p > 0) a[p-1] = 1'b0;
    s = r + a;
    t = 1'b1;
    for (int k = 0; k < 8; k++) if (s[p+k]) t = 1'b0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] r, input logic [31:0] im,
                       input logic [3:0] c, input string tag);
    item_t it;
    @(negedge clk);
    reg_i = r; imm_i = im; cond_i = c; valid_i = 1'b1;
    model(r, im, int'(c), 8, it.s8, it.t8);
    model(r, im, int'(c), 0, it.s0, it.t0);
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
      reg_i = 64'hDEAD_BEEF_0000_1111; imm_i = 32'h8000_0001; cond_i = 4'd9;
    end
  endtask

  // monitor: one ns after each edge, when outputs are settled
  always begin
    @(posedge clk);
    #1;
    if (rst_n && valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected valid_o", 64'd1, 64'd0);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        check(result_o == it.s8, {"R4 sum ", it.tag}, result_o, it.s8);
        check(taken_o == it.t8, {"R5 taken ", it.tag}, 64'(taken_o), 64'(it.t8));
        check(valid_z, {"R6 valid zero-offset ", it.tag}, 64'(valid_z), 64'd1);
        check(result_z == it.s0, {"R2 sum zero-offset ", it.tag}, result_z, it.s0);
        check(taken_z == it.t0, {"R2 taken zero-offset ", it.tag}, 64'(taken_z), 64'(it.t0));
        last_s8 = it.s8;
      end
    end
  end

  initial begin
    #1;
    check(valid_o == 1'b0, "R8 valid after reset", 64'(valid_o), 64'd0);
    check(taken_o == 1'b0, "R8 taken after reset", 64'(taken_o), 64'd0);
    check(result_o == '0, "R8 result after reset", result_o, 64'd0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(2);

    // R1 R5: cond 0, sum lands at 0x100 -> window 8..15 holds 1, not taken
    drive(64'd0, 32'd0, 4'd0, "R1 basic");
    // R5: sum exactly zero -> taken
    drive(-64'sd256, 32'd0, 4'd0, "R5 zero sum");
    // R2: all-ones immediate, bit p-1 cleared
    drive(64'd0, 32'hFFFF_FFFF, 4'd0, "R2 clear below");
    // R3: negative immediate sign extension
    drive(64'h0000_0001_0000_0000, 32'h8000_0000, 4'd5, "R3 sign ext");
    // R5 example: cond 3 window bits 11..18
    drive(64'h0000_0000_0008_0000 - 64'h800, 32'd0, 4'd3, "R5 just above window");
    drive(64'h0000_0000_0004_0000 - 64'h800, 32'd0, 4'd3, "R5 top window bit");
    drive(-64'sd2048, 32'd0, 4'd3, "R5 cond3 taken");
    // R4: carry out of bit 63 wraps
    drive(64'hFFFF_FFFF_FFFF_FFFF, 32'h7FFF_FFFF, 4'd15, "R4 wrap");
    // R2: zero-offset p = 0, imm -2 -> addend -1, reg 1 -> sum 0
    drive(64'd1, 32'hFFFF_FFFE, 4'd0, "R2 p zero");
    drive(64'h0123_4567_89AB_CDEF, 32'h0000_1234, 4'd15, "R1 top cond");
    // R6: back-to-back random stream
    for (int i = 0; i < 40; i++)
      drive({$urandom(), $urandom()}, $urandom(), 4'($urandom()), "R6 stream");
    idle(1);
    for (int i = 0; i < 20; i++) begin
      drive({$urandom(), 32'd0} & 64'hFFFF_FFFF_FFF8_0000, $urandom() & 32'hFFF8_0000,
            4'($urandom()), "R5 sparse");
      if (i % 3 == 0) idle(1);
    end
    idle(4);
    // R7: idle outputs
    @(posedge clk); #1;
    check(valid_o == 1'b0, "R7 valid idle", 64'(valid_o), 64'd0);
    check(taken_o == 1'b0, "R7 taken idle", 64'(taken_o), 64'd0);
    check(result_o == last_s8, "R7 result holds", result_o, last_s8);
    check(exp_q.size() == 0, "R6 all results returned", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule